// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block watches the synchronized input pins of one GPIO bank and turns selected pin activity into interrupt requests. Each pin has its own detection mode. It can sense a level (high or low) or an edge (rising or falling). In edge mode it can instead sense both edges. Every detected event sets a sticky per-pin status bit. Software clears that bit by writing a 1 to it. A per-pin mask decides whether a latched status bit drives the single combined interrupt line.

The mask only blocks propagation. Detection runs whether or not a pin is masked, so an event that arrives while a pin is masked stays latched and raises the interrupt as soon as the pin is unmasked. Software cannot write the mask directly. One write-only port clears mask bits and another sets them, in both cases only where the written bit is 1. The mask reads back through its own read-only address. A 32-bit register port gives access to all of this. Reads return data combinationally in the same cycle, and writes take effect at the next clock edge.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset every mask bit reads 1, and the status, type, polarity and both-edge registers read 0. irq_out is 0.
- R2: The mask reads at offset 0x20C. A 1 there means the pin is masked. A write to 0x20C leaves the mask unchanged.
- R3: A write to offset 0x210 clears each mask bit whose written bit is 1. Written 0 bits leave their mask bits unchanged.
- R4: A write to offset 0x214 sets each mask bit whose written bit is 1. Writing all ones masks every pin.
- R5: Status reads at offset 0x218. A 1 written to a status bit clears it. A 0 written to a status bit leaves it unchanged.
- R6: The type (0x21C), polarity (0x220) and both-edge (0x224) registers read back the value last written to them.
- R7: With type bit 1 and both-edge bit 0, a 0-to-1 change of the pin sets status when polarity is 1. A 1-to-0 change sets status when polarity is 0. The opposite edge does not set status.
- R8: With type bit 1 and both-edge bit 1, either pin edge sets status and polarity has no effect. With type bit 0, the both-edge bit has no effect.
- R9: With type bit 0, status is set on every cycle in which the pin equals its polarity bit. Clearing status therefore has no lasting effect while that level persists.
- R10: Detection continues while a pin is masked. A status bit latched while masked raises irq_out once the pin is unmasked.
- R11: irq_out is 1 exactly when some pin has status 1 and mask 0.
- R12: When a detection event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read while bus_sel is high |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data; combinational, 0 when not reading |
| pin_in | input | NPIN (32) | Synchronized pin levels |
| irq_out | output | 1 | Combined interrupt request |

## Verification
A pin change applied before a rising edge is compared with the previous pin sample at that edge. Its status bit therefore appears exactly one clock later. irq_out follows status and mask in the same cycle, with no further register. Register writes take effect at the edge that ends the write cycle, and reads are combinational. The bench drives every input at the falling edge and samples shortly after a falling edge, so each result is read one edge after the stimulus that caused it. For the same-cycle cases, the edge and the clear, or the level and the clear, are applied in the same cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int REG_ADDR_W = 12;

  localparam logic [REG_ADDR_W-1:0] OFS_MASK    = 12'h20C;
  localparam logic [REG_ADDR_W-1:0] OFS_UNMASK  = 12'h210;
  localparam logic [REG_ADDR_W-1:0] OFS_MASKSET = 12'h214;
  localparam logic [REG_ADDR_W-1:0] OFS_STAT    = 12'h218;
  localparam logic [REG_ADDR_W-1:0] OFS_TYPE    = 12'h21C;
  localparam logic [REG_ADDR_W-1:0] OFS_POL     = 12'h220;
  localparam logic [REG_ADDR_W-1:0] OFS_ANY     = 12'h224;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_MASK, SEL_UNMASK, SEL_MASKSET,
    SEL_STAT, SEL_TYPE, SEL_POL, SEL_ANY
  } reg_sel_e;

  // Map a byte offset onto the register it addresses.
  function automatic reg_sel_e decode_reg(input logic [REG_ADDR_W-1:0] addr);
    case (addr)
      OFS_MASK:    return SEL_MASK;
      OFS_UNMASK:  return SEL_UNMASK;
      OFS_MASKSET: return SEL_MASKSET;
      OFS_STAT:    return SEL_STAT;
      OFS_TYPE:    return SEL_TYPE;
      OFS_POL:     return SEL_POL;
      OFS_ANY:     return SEL_ANY;
      default:     return SEL_NONE;
    endcase
  endfunction

  // One pin's event condition for the current cycle.
  // edge_mode=0: level match; edge_mode=1: directed edge, or both edges.
  function automatic logic pin_hit(input logic now, input logic prev,
                                   input logic edge_mode, input logic pol,
                                   input logic both);
    if (!edge_mode)  return now == pol;
    else if (both)   return now ^ prev;
    else if (pol)    return now & ~prev;
    else             return ~now & prev;
  endfunction

endpackage

// File: rtl/gpio_irq_cfg.sv
module gpio_irq_cfg
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_fire,
  input  reg_sel_e        sel,
  input  logic [NPIN-1:0] wbits,
  output logic [NPIN-1:0] type_q,
  output logic [NPIN-1:0] pol_q,
  output logic [NPIN-1:0] any_q,
  output logic [NPIN-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_q <= '0;
      pol_q  <= '0;
      any_q  <= '0;
      mask_q <= '1;
    end else if (wr_fire) begin
      case (sel)
        SEL_TYPE:    type_q <= wbits;
        SEL_POL:     pol_q  <= wbits;
        SEL_ANY:     any_q  <= wbits;
        SEL_UNMASK:  mask_q <= mask_q & ~wbits;
        SEL_MASKSET: mask_q <= mask_q | wbits;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_core.sv
module gpio_irq_core
  import gpio_irq_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pin_in,
  input  logic [NPIN-1:0] type_q,
  input  logic [NPIN-1:0] pol_q,
  input  logic [NPIN-1:0] any_q,
  input  logic [NPIN-1:0] clr_vec,
  output logic [NPIN-1:0] hit_vec,
  output logic [NPIN-1:0] status_q
);

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    logic prev_q;
    logic stat_q;
    logic hit;

    assign hit = pin_hit(pin_in[g], prev_q, type_q[g], pol_q[g], any_q[g]);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        prev_q <= 1'b0;
        stat_q <= 1'b0;
      end else begin
        prev_q <= pin_in[g];
        if (hit)             stat_q <= 1'b1;   // set wins over clear
        else if (clr_vec[g]) stat_q <= 1'b0;
      end
    end

    assign hit_vec[g]  = hit;
    assign status_q[g] = stat_q;
  end

endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int DATA_W = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [REG_ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0]     bus_wdata,
  output logic [DATA_W-1:0]     bus_rdata,
  input  logic [NPIN-1:0]       pin_in,
  output logic                  irq_out
);

  reg_sel_e        sel_w;
  logic            wr_fire;
  logic [NPIN-1:0] wbits;
  logic [NPIN-1:0] type_q, pol_q, any_q, mask_q;
  logic [NPIN-1:0] status_q, hit_vec, clr_vec, pend_vec;
  logic [NPIN-1:0] rd_vec;

  assign sel_w   = decode_reg(bus_addr);
  assign wr_fire = bus_sel & bus_wr;
  assign wbits   = bus_wdata[NPIN-1:0];
  assign clr_vec = (wr_fire && sel_w == SEL_STAT) ? wbits : '0;

  gpio_irq_cfg #(.NPIN(NPIN)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_fire (wr_fire),
    .sel     (sel_w),
    .wbits   (wbits),
    .type_q  (type_q),
    .pol_q   (pol_q),
    .any_q   (any_q),
    .mask_q  (mask_q)
  );

  gpio_irq_core #(.NPIN(NPIN)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_in   (pin_in),
    .type_q   (type_q),
    .pol_q    (pol_q),
    .any_q    (any_q),
    .clr_vec  (clr_vec),
    .hit_vec  (hit_vec),
    .status_q (status_q)
  );

  assign pend_vec = status_q & ~mask_q;
  assign irq_out  = |pend_vec;

  always_comb begin
    rd_vec = '0;
    if (bus_sel && !bus_wr) begin
      case (sel_w)
        SEL_MASK: rd_vec = mask_q;
        SEL_STAT: rd_vec = status_q;
        SEL_TYPE: rd_vec = type_q;
        SEL_POL:  rd_vec = pol_q;
        SEL_ANY:  rd_vec = any_q;
        default:  rd_vec = '0;
      endcase
    end
  end

  assign bus_rdata = DATA_W'(rd_vec);

endmodule

// File: rtl/gpio_irq_detect_chk.sv
module gpio_irq_detect_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [REG_ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [NPIN-1:0]       mask_q,
  input logic [NPIN-1:0]       status_q,
  input logic [NPIN-1:0]       hit_vec,
  input logic                  irq_out
);

  logic wr_unmask, wr_maskset, wr_stat;
  assign wr_unmask  = bus_sel && bus_wr && bus_addr == OFS_UNMASK;
  assign wr_maskset = bus_sel && bus_wr && bus_addr == OFS_MASKSET;
  assign wr_stat    = bus_sel && bus_wr && bus_addr == OFS_STAT;

  p_unmask_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_unmask |=> ((mask_q & $past(bus_wdata[NPIN-1:0])) == '0));

  p_maskset_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_maskset |=> ((mask_q & $past(bus_wdata[NPIN-1:0])) == $past(bus_wdata[NPIN-1:0])));

  p_status_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_event_latched_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (|hit_vec) |=> ((status_q & $past(hit_vec)) == $past(hit_vec)));

  p_all_masked_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq_out);

endmodule

bind gpio_irq_detect gpio_irq_detect_chk #(.NPIN(NPIN), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .mask_q    (mask_q),
  .status_q  (status_q),
  .hit_vec   (hit_vec),
  .irq_out   (irq_out)
);

// File: tb/test_gpio_irq_detect.sv
module test_gpio_irq_detect;

  localparam logic [11:0] A_MASK = 12'h20C, A_UNM = 12'h210, A_MSET = 12'h214,
                          A_STAT = 12'h218, A_TYPE = 12'h21C, A_POL = 12'h220,
                          A_ANY  = 12'h224;

  // {edge_mode, pol, both, pin_before, pin_after, expect_status}
  localparam int NVEC = 12;
  localparam logic [5:0] VEC [NVEC] = '{
    6'b110_01_1, 6'b110_10_0,            // R7 rising
    6'b100_10_1, 6'b100_01_0,            // R7 falling
    6'b101_01_1, 6'b111_10_1, 6'b111_00_0, // R8 both edges
    6'b010_01_1, 6'b010_00_0,            // R9 level high
    6'b000_10_1, 6'b000_11_0,            // R9 level low
    6'b011_01_1                          // R8 both-edge bit ignored in level mode
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '1;
  logic        irq_out;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_detect i_gpio_irq_detect (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; the write commits at the next rising edge.
  task automatic wr_reg(input logic [11:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [11:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state (pins held high so the low-level default sees nothing)
    rd_reg(A_MASK, r); check("R1 mask", r, 32'hFFFF_FFFF);
    rd_reg(A_STAT, r); check("R1 status", r, 32'h0);
    rd_reg(A_TYPE, r); check("R1 type", r, 32'h0);
    rd_reg(A_POL,  r); check("R1 pol", r, 32'h0);
    rd_reg(A_ANY,  r); check("R1 any", r, 32'h0);
    check("R1 irq", {31'b0, irq_out}, 32'h0);

    // R2 mask address ignores writes
    wr_reg(A_MASK, 32'h0);
    rd_reg(A_MASK, r); check("R2 mask write ignored", r, 32'hFFFF_FFFF);

    // R6 readback
    wr_reg(A_TYPE, 32'hA5A5_0F0F); rd_reg(A_TYPE, r); check("R6 type", r, 32'hA5A5_0F0F);
    wr_reg(A_POL,  32'h3C3C_1234); rd_reg(A_POL,  r); check("R6 pol",  r, 32'h3C3C_1234);
    wr_reg(A_ANY,  32'h0F0F_8001); rd_reg(A_ANY,  r); check("R6 any",  r, 32'h0F0F_8001);

    // R7 R8 R9 detection table, applied to all pins at once
    for (int i = 0; i < NVEC; i++) begin
      pin_in = VEC[i][2] ? '1 : '0;
      wr_reg(A_TYPE, VEC[i][5] ? '1 : '0);
      wr_reg(A_POL,  VEC[i][4] ? '1 : '0);
      wr_reg(A_ANY,  VEC[i][3] ? '1 : '0);
      wr_reg(A_STAT, 32'hFFFF_FFFF);
      pin_in = VEC[i][1] ? '1 : '0;
      @(negedge clk);
      rd_reg(A_STAT, r);
      check($sformatf("R7/R8/R9 vector %0d", i), r, VEC[i][0] ? 32'hFFFF_FFFF : 32'h0);
    end

    // R3 / R4 mask set and clear ports
    wr_reg(A_UNM, 32'h0000_00F0); rd_reg(A_MASK, r); check("R3 unmask ones", r, 32'hFFFF_FF0F);
    wr_reg(A_UNM, 32'h0);         rd_reg(A_MASK, r); check("R3 unmask zeros", r, 32'hFFFF_FF0F);
    wr_reg(A_MSET, 32'h0000_0030); rd_reg(A_MASK, r); check("R4 mask set", r, 32'hFFFF_FF3F);
    wr_reg(A_MSET, 32'hFFFF_FFFF); rd_reg(A_MASK, r); check("R4 mask all", r, 32'hFFFF_FFFF);

    // R10 R11 R5 detection while masked
    pin_in = '0;
    wr_reg(A_TYPE, '1); wr_reg(A_POL, '1); wr_reg(A_ANY, '0);
    wr_reg(A_STAT, '1);
    pin_in[6] = 1'b1;
    @(negedge clk);
    rd_reg(A_STAT, r); check("R10 latched while masked", r, 32'h0000_0040);
    check("R11 masked irq low", {31'b0, irq_out}, 32'h0);
    wr_reg(A_STAT, 32'h0);
    rd_reg(A_STAT, r); check("R5 zero write keeps status", r, 32'h0000_0040);
    wr_reg(A_UNM, 32'h0000_0040);
    #1 check("R10 irq on unmask", {31'b0, irq_out}, 32'h1);
    wr_reg(A_STAT, 32'h0000_0040);
    rd_reg(A_STAT, r); check("R5 w1c", r, 32'h0);
    check("R11 irq drops", {31'b0, irq_out}, 32'h0);

    // R9 level persists through a clear
    wr_reg(A_TYPE, '0);
    wr_reg(A_STAT, 32'h0000_0040);
    rd_reg(A_STAT, r); check("R9 clear under active level", r, 32'h0000_0040);
    check("R11 irq with level", {31'b0, irq_out}, 32'h1);
    pin_in[6] = 1'b0;
    @(negedge clk);
    wr_reg(A_STAT, 32'h0000_0040);
    rd_reg(A_STAT, r); check("R9 clear after level gone", r, 32'h0);

    // R12 event and clear in the same cycle
    wr_reg(A_TYPE, '1);
    wr_reg(A_STAT, '1);
    pin_in[9] = 1'b1;
    wr_reg(A_STAT, 32'h0000_0200);
    rd_reg(A_STAT, r); check("R12 set beats clear", r, 32'h0000_0200);
    wr_reg(A_MSET, '1);
    #1 check("R11 masked status no irq", {31'b0, irq_out}, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule